// File: doc/BRIEF.md
# Flash ECC Status Evaluator

After a full-page flash read, a hardware decoder leaves one 4-bit error count for each 512-byte sector in a bank of packed 32-bit status words. This block walks the sectors that belong to one page buffer, one sector per clock. It adds every correctable count to a running corrected-bit total and keeps the largest count seen in any one sector of the current page.

A count of 15 marks a sector that could not be corrected. The walk stops at that sector. The block then scans the page buffer through a byte-wide memory port with one cycle of read latency, to decide whether the page is simply erased. The scan covers the whole main area and the ECC byte positions of the spare area. An erased page excuses the error. Any byte that is not 0xFF raises the uncorrectable flag.

A controller pulses `start` with the buffer number, the sectors-per-page count and the ECC strength. It then waits for the one-cycle `done` pulse and reads the results, which stay stable until the next start.

Top module: `flash_ecc_eval`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `uncorrectable`, `max_flips`, `corr_total` and `mem_rd_en` are all 0.
- R2: For buffer number b and s sectors per page, exactly sectors b*s through b*s+s-1 are evaluated. Sector n's count is in status word n/4 (word i at `ecc_stat[i*32 +: 32]`), at bits [(3-n%4)*8+3 : (3-n%4)*8]. The upper nibble of each byte is ignored.
- R3: One sector is evaluated per clock. When no evaluated count is 15, `done` is high for exactly one cycle, after the s-th rising edge that follows the edge sampling `start`.
- R4: `corr_total` adds the count of every correctable evaluated sector. It carries over from one evaluation to the next, is cleared only by reset, and wraps at its width.
- R5: `max_flips` is cleared when `start` is accepted and then holds the largest correctable count evaluated in that evaluation.
- R6: A count of 15 ends the sector walk. Sectors after it are neither added to `corr_total` nor compared for `max_flips`.
- R7: The erased-page scan reads scan index k at byte address base+k for k < page and at base+k+8 for k >= page. Here base = b*s*1024, page = s*512, and the index runs up to page + s*8 (`strong_ecc`=0) or page + s*16 (`strong_ecc`=1). Spare bytes 0 to 7 are never read.
- R8: `uncorrectable` rises if and only if a scanned byte differs from 0xFF. The scan stops at the first such byte, at scan index j. `done` follows j+2 edges after the sector edge. For an erased page it follows page+ECC-bytes+1 edges after that edge.
- R9: `uncorrectable` is cleared when `start` is accepted and otherwise holds its value between evaluations.
- R10: `start` is ignored while an evaluation is in progress. Its buffer, count and strength inputs are also ignored.
- R11: `mem_rd_en` is high only during the erased-page scan, with one read per cycle. A scan makes j+1 reads when it stops at index j, and reads every scan index on an erased page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an evaluation (accepted when idle) |
| buf_sel | input | BUF_W | Page buffer number |
| sect_count | input | STEP_W | 512-byte sectors per page (1 or more) |
| strong_ecc | input | 1 | 1: 16 ECC bytes per sector, 0: 8 |
| ecc_stat | input | MAX_SECTORS*8 | Packed status words, word i at [i*32 +: 32] |
| mem_rd_en | output | 1 | Page-buffer byte read request |
| mem_addr | output | ADDR_W | Page-buffer byte address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| uncorrectable | output | 1 | Page has an uncorrectable, non-erased sector |
| max_flips | output | 4 | Largest correctable count in the last evaluation |
| corr_total | output | CORR_W | Running corrected-bit total |

## Verification
The assertions assume that `sect_count` is at least 1 whenever `start` is accepted. They also assume that buffer times count stays inside the status bank, and that `mem_rdata` answers the previous cycle's address. The bench meets these assumptions by using only non-zero counts with buffer ranges below sector 16. Its memory model returns the addressed byte one edge after each request. The bench raises `start` with changed inputs only in cycles where the block is already busy, so the ignored-start case cannot overlap a legitimate accept.

// File: rtl/fecc_pkg.sv
package fecc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SECT = 2'd1,
    ST_SCAN = 2'd2
  } fecc_state_e;

  localparam logic [3:0] CNT_UNCORR = 4'hF;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/fecc_sector_pick.sv
module fecc_sector_pick #(
  parameter int MAX_SECTORS = 16,
  parameter int SEC_W       = 4
) (
  input  logic [MAX_SECTORS*8-1:0] stat_flat,
  input  logic [SEC_W-1:0]         sel,
  output logic [3:0]               count
);
  logic [3:0] nib [MAX_SECTORS];
  logic [MAX_SECTORS*4-1:0] unused_hi;

  // Lowest sector of a word sits in its most significant byte; count in low nibble.
  for (genvar g = 0; g < MAX_SECTORS; g++) begin : g_nib
    localparam int LSB = (g / 4) * 32 + (3 - (g % 4)) * 8;
    assign nib[g]             = stat_flat[LSB +: 4];
    assign unused_hi[g*4 +: 4] = stat_flat[LSB + 4 +: 4];
  end

  assign count = nib[sel];
endmodule

// File: rtl/fecc_accum.sv
module fecc_accum #(
  parameter int CORR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_max,
  input  logic              acc_en,
  input  logic [3:0]        count,
  output logic [CORR_W-1:0] corr_total,
  output logic [3:0]        max_flips
);
  logic [CORR_W-1:0] corr_d;
  logic [3:0]        max_d;
  logic              corr_en;
  logic              max_en;

  always_comb begin
    corr_en = acc_en;
    corr_d  = corr_total + CORR_W'(count);
    max_en  = clr_max || (acc_en && (count > max_flips));
    max_d   = clr_max ? 4'd0 : count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_total <= '0;
      max_flips  <= '0;
    end else begin
      if (corr_en) corr_total <= corr_d;
      if (max_en)  max_flips  <= max_d;
    end
  end
endmodule

// File: rtl/fecc_blank_scan.sv
module fecc_blank_scan #(
  parameter int ADDR_W  = 15,
  parameter int ECC_OFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] page_bytes,
  input  logic [ADDR_W-1:0] total,
  input  logic [7:0]        rdata,
  output logic              rd_en,
  output logic [ADDR_W-1:0] addr,
  output logic              fin,
  output logic              dirty
);
  import fecc_pkg::*;

  logic              active_q, active_d;
  logic              pend_q,   pend_d;
  logic [ADDR_W-1:0] idx_q,    idx_d;
  logic              at_end;
  logic              mismatch;

  always_comb begin
    at_end   = (idx_q == total);
    mismatch = active_q && pend_q && (rdata != ERASED_BYTE);
    rd_en    = active_q && !at_end && !mismatch;
    fin      = active_q && (mismatch || at_end);
    dirty    = mismatch;
    addr     = base + idx_q + ((idx_q >= page_bytes) ? ADDR_W'(ECC_OFS) : '0);
  end

  always_comb begin
    active_d = active_q;
    pend_d   = pend_q;
    idx_d    = idx_q;
    if (go) begin
      active_d = 1'b1;
      pend_d   = 1'b0;
      idx_d    = '0;
    end else if (active_q) begin
      if (fin) begin
        active_d = 1'b0;
        pend_d   = 1'b0;
      end else begin
        pend_d = rd_en;
        idx_d  = idx_q + ADDR_W'(rd_en);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      pend_q   <= pend_d;
      idx_q    <= idx_d;
    end
  end
endmodule

// File: rtl/flash_ecc_eval.sv
module flash_ecc_eval #(
  parameter int SECT_BYTES  = 512,
  parameter int MAX_SECTORS = 16,
  parameter int BUF_W       = 4,
  parameter int STEP_W      = 4,
  parameter int ADDR_W      = 15,
  parameter int CORR_W      = 16,
  parameter int ECC_OFS     = 8,
  parameter int ECC_LO      = 8,
  parameter int ECC_HI      = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [BUF_W-1:0]         buf_sel,
  input  logic [STEP_W-1:0]        sect_count,
  input  logic                     strong_ecc,
  input  logic [MAX_SECTORS*8-1:0] ecc_stat,
  output logic                     mem_rd_en,
  output logic [ADDR_W-1:0]        mem_addr,
  input  logic [7:0]               mem_rdata,
  output logic                     done,
  output logic                     uncorrectable,
  output logic [3:0]               max_flips,
  output logic [CORR_W-1:0]        corr_total
);
  import fecc_pkg::*;

  localparam int SEC_W = (MAX_SECTORS > 1) ? $clog2(MAX_SECTORS) : 1;

  fecc_state_e       state_q, state_d;
  logic [SEC_W-1:0]  cur_sec_q, cur_sec_d;
  logic [STEP_W-1:0] left_q, left_d;
  logic [BUF_W-1:0]  buf_q;
  logic [STEP_W-1:0] steps_q;
  logic              str8_q;
  logic              unc_q, unc_d;
  logic              done_q, done_d;
  logic              cfg_ld, sec_en;
  logic              clr_max, acc_en, scan_go;
  logic              busy;

  logic [3:0]        sec_cnt;
  logic              scan_fin, scan_dirty;
  logic [ADDR_W-1:0] page_bytes, ecc_bytes, scan_total, base_addr;

  // Geometry of the latched page.
  always_comb begin
    page_bytes = ADDR_W'(steps_q) * ADDR_W'(SECT_BYTES);
    ecc_bytes  = ADDR_W'(steps_q) * (str8_q ? ADDR_W'(ECC_HI) : ADDR_W'(ECC_LO));
    scan_total = page_bytes + ecc_bytes;
    base_addr  = ADDR_W'(buf_q) * page_bytes * ADDR_W'(2);
  end

  fecc_sector_pick #(
    .MAX_SECTORS(MAX_SECTORS),
    .SEC_W      (SEC_W)
  ) u_pick (
    .stat_flat(ecc_stat),
    .sel      (cur_sec_q),
    .count    (sec_cnt)
  );

  // Next-state logic.
  always_comb begin
    state_d   = state_q;
    cur_sec_d = cur_sec_q;
    left_d    = left_q;
    unc_d     = unc_q;
    done_d    = 1'b0;
    cfg_ld    = 1'b0;
    sec_en    = 1'b0;
    clr_max   = 1'b0;
    acc_en    = 1'b0;
    scan_go   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d   = ST_SECT;
          cfg_ld    = 1'b1;
          sec_en    = 1'b1;
          cur_sec_d = SEC_W'(SEC_W'(buf_sel) * SEC_W'(sect_count));
          left_d    = sect_count - STEP_W'(1);
          unc_d     = 1'b0;
          clr_max   = 1'b1;
        end
      end
      ST_SECT: begin
        if (sec_cnt == CNT_UNCORR) begin
          state_d = ST_SCAN;
          scan_go = 1'b1;
        end else begin
          acc_en = 1'b1;
          if (left_q == '0) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            sec_en    = 1'b1;
            cur_sec_d = cur_sec_q + SEC_W'(1);
            left_d    = left_q - STEP_W'(1);
          end
        end
      end
      ST_SCAN: begin
        if (scan_fin) begin
          state_d = ST_IDLE;
          unc_d   = scan_dirty;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_sec_q <= '0;
      left_q    <= '0;
      buf_q     <= '0;
      steps_q   <= '0;
      str8_q    <= 1'b0;
      unc_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      unc_q   <= unc_d;
      done_q  <= done_d;
      if (cfg_ld) begin
        buf_q   <= buf_sel;
        steps_q <= sect_count;
        str8_q  <= strong_ecc;
      end
      if (sec_en) begin
        cur_sec_q <= cur_sec_d;
        left_q    <= left_d;
      end
    end
  end

  fecc_accum #(
    .CORR_W(CORR_W)
  ) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_max   (clr_max),
    .acc_en    (acc_en),
    .count     (sec_cnt),
    .corr_total(corr_total),
    .max_flips (max_flips)
  );

  fecc_blank_scan #(
    .ADDR_W (ADDR_W),
    .ECC_OFS(ECC_OFS)
  ) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (scan_go),
    .base      (base_addr),
    .page_bytes(page_bytes),
    .total     (scan_total),
    .rdata     (mem_rdata),
    .rd_en     (mem_rd_en),
    .addr      (mem_addr),
    .fin       (scan_fin),
    .dirty     (scan_dirty)
  );

  assign busy          = (state_q != ST_IDLE);
  assign done          = done_q;
  assign uncorrectable = unc_q;
endmodule

// File: rtl/fecc_checker.sv
module fecc_checker #(
  parameter int ADDR_W = 15,
  parameter int CORR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              unc,
  input logic [3:0]        max_flips,
  input logic [CORR_W-1:0] corr_total
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3

  AST_READ_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy); // R11

  AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |->
      ((addr == $past(addr) + ADDR_W'(1)) || (addr == $past(addr) + ADDR_W'(9)))); // R7

  AST_MAX_CORRECTABLE: assert property (@(posedge clk) disable iff (!rst_n)
    max_flips != 4'hF); // R5

  AST_CORR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_total != $past(corr_total)) |->
      (CORR_W'(corr_total - $past(corr_total)) < CORR_W'(15))); // R4

  AST_UNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(unc)); // R9

  AST_UNC_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unc) |-> done); // R8
endmodule

bind flash_ecc_eval fecc_checker #(
  .ADDR_W(ADDR_W),
  .CORR_W(CORR_W)
) u_fecc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .rd_en     (mem_rd_en),
  .addr      (mem_addr),
  .unc       (uncorrectable),
  .max_flips (max_flips),
  .corr_total(corr_total)
);

// File: tb/test_flash_ecc_eval.sv
module test_flash_ecc_eval;
  localparam int ADDR_W = 15;
  localparam int CORR_W = 16;
  localparam int MEMSZ  = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [3:0]        buf_sel;
  logic [3:0]        sect_count;
  logic              strong_ecc;
  logic [127:0]      ecc_stat;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_rdata;
  logic              done;
  logic              uncorrectable;
  logic [3:0]        max_flips;
  logic [CORR_W-1:0] corr_total;

  logic [31:0] stat_w [4];
  logic [7:0]  mem [MEMSZ];

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  int exp_corr = 0;

  flash_ecc_eval i_flash_ecc_eval (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .buf_sel      (buf_sel),
    .sect_count   (sect_count),
    .strong_ecc   (strong_ecc),
    .ecc_stat     (ecc_stat),
    .mem_rd_en    (mem_rd_en),
    .mem_addr     (mem_addr),
    .mem_rdata    (mem_rdata),
    .done         (done),
    .uncorrectable(uncorrectable),
    .max_flips    (max_flips),
    .corr_total   (corr_total)
  );

  assign ecc_stat = {stat_w[3], stat_w[2], stat_w[1], stat_w[0]};

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Page buffer with one cycle of read latency.
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nib(input int s);
    return (stat_w[s / 4] >> ((3 - (s % 4)) * 8)) & 15;
  endfunction

  function automatic int xaddr(input int b, input int st, input int k);
    return b * st * 1024 + k + ((k >= st * 512) ? 8 : 0);
  endfunction

  // Behavioural reference: latency in edges after the start edge, and results.
  task automatic model(input int b, input int st, input bit s8,
                       output int lat, output int unc, output int mx,
                       output int cd, output int nreads);
    bit stop = 0;
    lat = 0; unc = 0; mx = 0; cd = 0; nreads = 0;
    for (int s = b * st; s < b * st + st && !stop; s++) begin
      int c = nib(s);
      lat++;
      if (c == 15) begin
        int total = st * 512 + st * (s8 ? 16 : 8);
        int found = -1;
        stop = 1;
        for (int k = 0; k < total && found < 0; k++)
          if (mem[xaddr(b, st, k)] != 8'hFF) found = k;
        if (found >= 0) begin
          lat += 2 + found; unc = 1; nreads = found + 1;
        end else begin
          lat += 1 + total; nreads = total;
        end
      end else begin
        cd += c;
        if (c > mx) mx = c;
      end
    end
  endtask

  task automatic run_case(input int b, input int st, input bit s8,
                          input bit glitch, input string tag);
    int lat, unc, mx, cd, nreads;
    int reads = 0;
    model(b, st, s8, lat, unc, mx, cd, nreads);
    exp_corr = (exp_corr + cd) % (1 << CORR_W);
    @(negedge clk);
    buf_sel = 4'(b); sect_count = 4'(st); strong_ecc = s8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R3 done low after start"}, int'(done), 0);
    for (int n = 1; n <= lat; n++) begin
      @(negedge clk);
      if (mem_rd_en) begin
        chk({tag, " R7 scan address"}, int'(mem_addr), xaddr(b, st, reads));
        reads++;
      end
      chk({tag, " R3 R8 done timing"}, int'(done), (n == lat) ? 1 : 0);
      if (glitch && n == 1) begin
        // R10: start with other inputs while busy
        start = 1'b1; buf_sel = 4'(b + 1); sect_count = 4'(st + 1); strong_ecc = !s8;
      end
      if (glitch && n == 2) start = 1'b0;
    end
    chk({tag, " R8 uncorrectable"}, int'(uncorrectable), unc);
    chk({tag, " R5 max_flips"}, int'(max_flips), mx);
    chk({tag, " R4 corr_total"}, int'(corr_total), exp_corr);
    chk({tag, " R11 read count"}, reads, nreads);
    @(negedge clk);
    chk({tag, " R3 done pulse width"}, int'(done), 0);
    chk({tag, " R9 unc holds"}, int'(uncorrectable), unc);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected=<150000", wd);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int a = 0; a < MEMSZ; a++) mem[a] = 8'hFF;
    for (int w = 0; w < 4; w++) stat_w[w] = 32'h0;
    rst_n = 1'b0; start = 1'b0; buf_sel = '0; sect_count = 4'd1; strong_ecc = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done", int'(done), 0);
    chk("R1 uncorrectable", int'(uncorrectable), 0);
    chk("R1 max_flips", int'(max_flips), 0);
    chk("R1 corr_total", int'(corr_total), 0);
    chk("R1 mem_rd_en", int'(mem_rd_en), 0);

    // R2 R3 R5: plain counts, with an ignored start while busy (R10)
    stat_w[0] = 32'h01_02_00_03;
    run_case(0, 4, 0, 1, "R2 R10 buf0x4");
    // R2: upper nibbles ignored, second word
    stat_w[1] = 32'hA5_30_F1_00;
    run_case(1, 4, 0, 0, "R2 buf1x4");
    // R2 R5: tail of word 1, max cleared from previous 5
    run_case(3, 2, 0, 0, "R2 R5 buf3x2");
    // R2: last sector of the bank
    stat_w[3] = 32'h00_00_00_07;
    run_case(15, 1, 0, 0, "R2 buf15x1");
    // R5: all zero counts give max 0
    stat_w[2] = 32'h0;
    run_case(2, 4, 0, 0, "R5 buf2x4");

    // R6 R8: uncorrectable at sector 2, main area dirty at byte 5
    stat_w[0] = 32'h04_01_0F_09;
    mem[5] = 8'h00;
    run_case(0, 4, 0, 0, "R6 R8 dirty");
    mem[5] = 8'hFF;
    // R7 R9 R10: erased page, spare byte 2 not an ECC position
    mem[2048 + 2] = 8'h12;
    run_case(0, 4, 0, 1, "R7 R9 erased");
    // R7: byte at ECC index 40 lies outside 8-byte-per-sector range
    mem[2048 + 8 + 40] = 8'h00;
    run_case(0, 4, 0, 0, "R7 weak ecc range");
    // R7 R8: same byte inside 16-byte-per-sector range
    run_case(0, 4, 1, 0, "R7 R8 strong ecc range");
    mem[2048 + 8 + 40] = 8'hFF;
    mem[2048 + 2] = 8'hFF;

    // R6 R8 R11: first sector uncorrectable, first scanned byte dirty
    stat_w[1] = 32'h0F_02_00_00;
    mem[4096] = 8'h7E;
    run_case(2, 2, 0, 0, "R6 R11 first byte");
    mem[4096] = 8'hFF;
    // R9: flag cleared by next start
    run_case(3, 2, 0, 0, "R9 clear");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule